// File: doc/BRIEF.md
# Non-Maskable Interrupt Edge Detector and Acceptance Gate

This block turns one asynchronous external pin into a non-maskable interrupt request for the CPU. The pin is first brought into the bus clock domain by a two-flop synchronizer. The block then looks for an edge of a programmable polarity. A detected edge sets a sticky pending flag, and the flag stays set until the CPU returns a one-cycle accept pulse. The block always reports a fixed priority of 16, which ranks above every maskable source.

When software writes the edge polarity, detection is suppressed for a settling window. The reference flop keeps tracking the synchronized pin throughout that window, so a change of polarity alone never looks like an edge. Whether the pending request is offered to the CPU depends on three inputs: the CPU's block bit, a sleep indication and an override bit. When the CPU accepts the request, the block either forces the new interrupt mask level to 15 or passes the current level through unchanged, depending on a mask-update enable.

Top module: `nmi_gate`

## Requirements
- R1: After a synchronous reset, `nmi_req_o`, `nmi_pend_o` and `mask_load_o` are 0 and `mask_o` is 0.
- R2: With `edge_rise_i`=1, a 0-to-1 change on `nmi_pin_i` sets `nmi_pend_o` at the third rising clock edge after the change. The request is then visible on `nmi_req_o` when acceptance is allowed.
- R3: With `edge_rise_i`=0, a 1-to-0 change on `nmi_pin_i` sets `nmi_pend_o` with the same three-edge latency. An edge of the other polarity is ignored.
- R4: No edge is detected in the cycle in which `edge_sel_wr_i` is 1, nor in the 6 cycles that follow it. Each new write restarts this window.
- R5: Changing `edge_rise_i` while `nmi_pin_i` stays at a constant level never sets `nmi_pend_o`.
- R6: `nmi_pend_o` stays at 1 until a cycle in which `accept_i` is 1, and it is 0 after that edge. `nmi_req_o` is never 1 while `nmi_pend_o` is 0.
- R7: If an edge is detected in the same cycle as `accept_i`, `nmi_pend_o` stays at 1.
- R8: With `cpu_block_i`=1, `sleep_i`=0 and `blk_override_i`=0, `nmi_req_o` is 0 at the following clock edge, while `nmi_pend_o` keeps its value.
- R9: With `sleep_i`=1, the request is offered even when `cpu_block_i`=1.
- R10: With `blk_override_i`=1, the request is offered even when `cpu_block_i`=1.
- R11: An accept (`accept_i`=1 while `nmi_req_o`=1) with `mask_upd_en_i`=1 makes `mask_o` equal to 15 and `mask_load_o` equal to 1 for one cycle at the next edge.
- R12: In every other cycle, `mask_o` takes the value of `cur_mask_i` from the previous cycle and `mask_load_o` is 0.
- R13: `prio_o` always reads 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_pin_i | input | 1 | Asynchronous interrupt pin |
| edge_rise_i | input | 1 | Edge polarity: 1 selects rising, 0 selects falling |
| edge_sel_wr_i | input | 1 | One-cycle strobe marking a write to the polarity setting |
| cpu_block_i | input | 1 | CPU block bit |
| sleep_i | input | 1 | CPU is in sleep mode |
| blk_override_i | input | 1 | Accept even while the block bit is set |
| mask_upd_en_i | input | 1 | Force the mask level to 15 on acceptance |
| cur_mask_i | input | 4 | Current CPU interrupt mask level |
| accept_i | input | 1 | One-cycle CPU acceptance pulse |
| nmi_req_o | output | 1 | Request offered to the CPU (registered) |
| nmi_pend_o | output | 1 | Pending flag |
| mask_o | output | 4 | New interrupt mask level for the status register |
| mask_load_o | output | 1 | One-cycle pulse when `mask_o` was forced |
| prio_o | output | 5 | Fixed priority level of the request |

## Verification
The assertions assume that `accept_i` is only pulsed in a cycle where `nmi_req_o` is 1, and that `edge_sel_wr_i` is high in the same cycle as any change of `edge_rise_i`. The stimulus meets the first assumption by deriving every accept pulse from the sampled request. It meets the second by changing polarity only inside the write task, which also raises the strobe. Pin activity, mask values and gating inputs vary freely, including pin pulses that land inside a blackout window and accept pulses that coincide with a fresh edge.

// File: rtl/nmi_pkg.sv
package nmi_pkg;
  localparam int unsigned MASK_W        = 4;
  localparam int unsigned PRIO_W        = 5;
  localparam int unsigned NMI_PRIO      = 16;
  localparam int unsigned FORCED_MASK   = 15;
  localparam int unsigned SYNC_STAGES   = 2;
  localparam int unsigned BLACKOUT_CYC  = 6;

  typedef logic [MASK_W-1:0] mask_t;
  typedef logic [PRIO_W-1:0] prio_t;
endpackage

// File: rtl/nmi_sync.sv
module nmi_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b0;
          else     chain_q[g] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b0;
          else     chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/nmi_edge_det.sv
module nmi_edge_det #(
  parameter int unsigned BLACKOUT_CYC = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic sync_i,
  input  logic edge_rise_i,
  input  logic sel_wr_i,
  output logic edge_o
);
  localparam int unsigned CNT_W = $clog2(BLACKOUT_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BLACKOUT_CYC);

  logic             ref_q;
  logic [CNT_W-1:0] quiet_cnt_q;
  logic             quiet;
  logic             raw_edge;

  // The reference keeps following the pin, including during the quiet
  // window, so the comparison is always made against a fresh value.
  always_ff @(posedge clk) begin
    if (rst) ref_q <= 1'b0;
    else     ref_q <= sync_i;
  end

  always_ff @(posedge clk) begin
    if (rst)                    quiet_cnt_q <= '0;
    else if (sel_wr_i)          quiet_cnt_q <= CNT_LOAD;
    else if (quiet_cnt_q != '0) quiet_cnt_q <= quiet_cnt_q - 1'b1;
  end

  assign quiet    = sel_wr_i | (quiet_cnt_q != '0);
  assign raw_edge = edge_rise_i ? (sync_i & ~ref_q) : (~sync_i & ref_q);
  assign edge_o   = raw_edge & ~quiet;
endmodule

// File: rtl/nmi_accept_gate.sv
module nmi_accept_gate
  import nmi_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  edge_i,
  input  logic  accept_i,
  input  logic  cpu_block_i,
  input  logic  sleep_i,
  input  logic  blk_override_i,
  input  logic  mask_upd_en_i,
  input  mask_t cur_mask_i,
  output logic  req_o,
  output logic  pend_o,
  output mask_t mask_o,
  output logic  mask_load_o
);
  logic  pend_q, pend_d;
  logic  req_q;
  logic  allow;
  logic  taken;
  mask_t mask_q;
  logic  load_q;

  assign allow  = ~cpu_block_i | sleep_i | blk_override_i;
  assign taken  = accept_i & req_q;
  // A fresh edge outranks the clear.
  assign pend_d = edge_i | (pend_q & ~accept_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      req_q  <= 1'b0;
      mask_q <= '0;
      load_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      req_q  <= pend_d & allow;
      load_q <= taken & mask_upd_en_i;
      mask_q <= (taken & mask_upd_en_i) ? mask_t'(FORCED_MASK) : cur_mask_i;
    end
  end

  assign pend_o      = pend_q;
  assign req_o       = req_q;
  assign mask_o      = mask_q;
  assign mask_load_o = load_q;
endmodule

// File: rtl/nmi_gate.sv
module nmi_gate
  import nmi_pkg::*;
#(
  parameter int unsigned STAGES   = SYNC_STAGES,
  parameter int unsigned BLACKOUT = BLACKOUT_CYC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              nmi_pin_i,
  input  logic              edge_rise_i,
  input  logic              edge_sel_wr_i,
  input  logic              cpu_block_i,
  input  logic              sleep_i,
  input  logic              blk_override_i,
  input  logic              mask_upd_en_i,
  input  logic [MASK_W-1:0] cur_mask_i,
  input  logic              accept_i,
  output logic              nmi_req_o,
  output logic              nmi_pend_o,
  output logic [MASK_W-1:0] mask_o,
  output logic              mask_load_o,
  output logic [PRIO_W-1:0] prio_o
);
  logic pin_sync;
  logic edge_hit;

  nmi_sync #(.STAGES(STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (nmi_pin_i),
    .sync_o  (pin_sync)
  );

  nmi_edge_det #(.BLACKOUT_CYC(BLACKOUT)) u_edge (
    .clk         (clk),
    .rst         (rst),
    .sync_i      (pin_sync),
    .edge_rise_i (edge_rise_i),
    .sel_wr_i    (edge_sel_wr_i),
    .edge_o      (edge_hit)
  );

  nmi_accept_gate u_gate (
    .clk            (clk),
    .rst            (rst),
    .edge_i         (edge_hit),
    .accept_i       (accept_i),
    .cpu_block_i    (cpu_block_i),
    .sleep_i        (sleep_i),
    .blk_override_i (blk_override_i),
    .mask_upd_en_i  (mask_upd_en_i),
    .cur_mask_i     (cur_mask_i),
    .req_o          (nmi_req_o),
    .pend_o         (nmi_pend_o),
    .mask_o         (mask_o),
    .mask_load_o    (mask_load_o)
  );

  assign prio_o = PRIO_W'(NMI_PRIO);
endmodule

// File: rtl/nmi_gate_chk.sv
module nmi_gate_chk
  import nmi_pkg::*;
#(
  parameter int unsigned BLACKOUT = BLACKOUT_CYC
) (
  input logic              clk,
  input logic              rst,
  input logic              edge_sel_wr_i,
  input logic              cpu_block_i,
  input logic              sleep_i,
  input logic              blk_override_i,
  input logic              mask_upd_en_i,
  input logic [MASK_W-1:0] cur_mask_i,
  input logic              accept_i,
  input logic              nmi_req_o,
  input logic              nmi_pend_o,
  input logic [MASK_W-1:0] mask_o,
  input logic              mask_load_o
);
  int unsigned win_q;

  always_ff @(posedge clk) begin
    if (rst)                win_q <= 0;
    else if (edge_sel_wr_i) win_q <= BLACKOUT;
    else if (win_q != 0)    win_q <= win_q - 1;
  end

  // R4: the pending flag cannot rise out of a quiet cycle
  a_r4_quiet_no_edge: assert property (@(posedge clk) disable iff (rst)
    (edge_sel_wr_i || win_q != 0) && !nmi_pend_o |=> !nmi_pend_o);

  // R6: pending holds without an accept
  a_r6_pend_holds: assert property (@(posedge clk) disable iff (rst)
    nmi_pend_o && !accept_i |=> nmi_pend_o);

  // R6: no request without pending
  a_r6_req_needs_pend: assert property (@(posedge clk) disable iff (rst)
    nmi_req_o |-> nmi_pend_o);

  // R8: blocked means no request offered
  a_r8_blocked: assert property (@(posedge clk) disable iff (rst)
    cpu_block_i && !sleep_i && !blk_override_i |=> !nmi_req_o);

  // R11: forced mask level on acceptance
  a_r11_force_mask: assert property (@(posedge clk) disable iff (rst)
    accept_i && nmi_req_o && mask_upd_en_i |=> (mask_o == 4'd15) && mask_load_o);

  // R12: mask passes through otherwise
  a_r12_mask_follow: assert property (@(posedge clk) disable iff (rst)
    !(accept_i && nmi_req_o && mask_upd_en_i) |=>
      (mask_o == $past(cur_mask_i)) && !mask_load_o);
endmodule

bind nmi_gate nmi_gate_chk #(.BLACKOUT(BLACKOUT)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .edge_sel_wr_i  (edge_sel_wr_i),
  .cpu_block_i    (cpu_block_i),
  .sleep_i        (sleep_i),
  .blk_override_i (blk_override_i),
  .mask_upd_en_i  (mask_upd_en_i),
  .cur_mask_i     (cur_mask_i),
  .accept_i       (accept_i),
  .nmi_req_o      (nmi_req_o),
  .nmi_pend_o     (nmi_pend_o),
  .mask_o         (mask_o),
  .mask_load_o    (mask_load_o)
);

// File: tb/nmi_gate_tb_top.sv
module nmi_gate_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       nmi_pin_i = 1'b0, edge_rise_i = 1'b1, edge_sel_wr_i = 1'b0;
  logic       cpu_block_i = 1'b0, sleep_i = 1'b0, blk_override_i = 1'b0;
  logic       mask_upd_en_i = 1'b1, accept_i = 1'b0;
  logic [3:0] cur_mask_i = 4'd3;
  logic       nmi_req_o, nmi_pend_o, mask_load_o;
  logic [3:0] mask_o;
  logic [4:0] prio_o;

  int vectors = 0;
  int fails   = 0;
  string tag  = "R1";

  always #4 clk = ~clk;

  nmi_gate dut_i (
    .clk(clk), .rst(rst), .nmi_pin_i(nmi_pin_i), .edge_rise_i(edge_rise_i),
    .edge_sel_wr_i(edge_sel_wr_i), .cpu_block_i(cpu_block_i), .sleep_i(sleep_i),
    .blk_override_i(blk_override_i), .mask_upd_en_i(mask_upd_en_i),
    .cur_mask_i(cur_mask_i), .accept_i(accept_i), .nmi_req_o(nmi_req_o),
    .nmi_pend_o(nmi_pend_o), .mask_o(mask_o), .mask_load_o(mask_load_o),
    .prio_o(prio_o)
  );

  // Behavioural reference: a pin history queue, a quiet-cycle counter
  // and the expected outputs.
  bit  pin_hist[$];
  int  quiet_left = 0;
  bit  e_req = 0, e_pend = 0, e_load = 0;
  int  e_mask = 0;

  always @(posedge clk) begin
    bit cur, old, hit, take, allow;
    if (rst) begin
      pin_hist = {};
      quiet_left = 0;
      e_req = 0; e_pend = 0; e_load = 0; e_mask = 0;
    end else begin
      // synchronized sample = pin two edges ago; reference = three edges ago
      cur = (pin_hist.size() >= 2) ? pin_hist[pin_hist.size()-2] : 1'b0;
      old = (pin_hist.size() >= 3) ? pin_hist[pin_hist.size()-3] : 1'b0;
      hit = (edge_rise_i ? (cur && !old) : (!cur && old))
            && !edge_sel_wr_i && quiet_left == 0;
      take  = accept_i && e_req;
      allow = !cpu_block_i || sleep_i || blk_override_i;
      e_pend = hit || (e_pend && !accept_i);
      e_req  = e_pend && allow;
      e_load = take && mask_upd_en_i;
      e_mask = e_load ? 15 : int'(cur_mask_i);
      if (edge_sel_wr_i) quiet_left = 6;
      else if (quiet_left > 0) quiet_left--;
      pin_hist.push_back(nmi_pin_i);
      if (pin_hist.size() > 4) void'(pin_hist.pop_front());
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      vectors++;
      if (nmi_req_o !== e_req || nmi_pend_o !== e_pend || mask_load_o !== e_load
          || int'(mask_o) != e_mask || prio_o !== 5'd16) begin
        fails++;
        $display("FAIL %s: req/pend/load/mask/prio = %0b/%0b/%0b/%0d/%0d expected %0b/%0b/%0b/%0d/16",
                 tag, nmi_req_o, nmi_pend_o, mask_load_o, mask_o, prio_o,
                 e_req, e_pend, e_load, e_mask);
      end
    end
  end

  task automatic expect_bit(string t, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", t, act, exp);
    end
  endtask

  task automatic cycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write_pol(logic rise);
    edge_rise_i = rise; edge_sel_wr_i = 1'b1;
    @(negedge clk);
    edge_sel_wr_i = 1'b0;
  endtask

  task automatic accept_now();
    accept_i = 1'b1;
    @(negedge clk);
    accept_i = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    cycles(3);
    rst = 1'b0;
    @(negedge clk);
    tag = "R1";
    expect_bit("R1 pend", nmi_pend_o, 1'b0);
    expect_bit("R1 req", nmi_req_o, 1'b0);
    expect_bit("R13 prio", prio_o == 5'd16, 1'b1);

    tag = "R2";
    nmi_pin_i = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    expect_bit("R2 not before third edge", nmi_pend_o, 1'b0);
    @(posedge clk); #1;
    expect_bit("R2 pend at third edge", nmi_pend_o, 1'b1);
    @(negedge clk);
    tag = "R6"; cycles(5);
    expect_bit("R6 held", nmi_pend_o, 1'b1);
    tag = "R11"; accept_now();
    expect_bit("R11 forced", mask_o == 4'd15, 1'b1);
    expect_bit("R6 cleared", nmi_pend_o, 1'b0);

    tag = "R3"; write_pol(1'b0); cycles(10);
    nmi_pin_i = 1'b0; cycles(5);
    expect_bit("R3 falling", nmi_pend_o, 1'b1);
    tag = "R12"; mask_upd_en_i = 1'b0; cur_mask_i = 4'd9; accept_now();
    expect_bit("R12 follow", mask_o == 4'd9, 1'b1);
    nmi_pin_i = 1'b1; cycles(6);
    expect_bit("R3 rising ignored", nmi_pend_o, 1'b0);

    tag = "R5"; write_pol(1'b1); cycles(8); write_pol(1'b0); cycles(8);
    expect_bit("R5 polarity only", nmi_pend_o, 1'b0);

    tag = "R4"; nmi_pin_i = 1'b1; cycles(5); write_pol(1'b0);
    nmi_pin_i = 1'b0; cycles(10);
    expect_bit("R4 lost in window", nmi_pend_o, 1'b0);

    tag = "R8"; cpu_block_i = 1'b1; nmi_pin_i = 1'b1; cycles(4); nmi_pin_i = 1'b0; cycles(4);
    expect_bit("R8 pend", nmi_pend_o, 1'b1);
    expect_bit("R8 no req", nmi_req_o, 1'b0);
    tag = "R9"; sleep_i = 1'b1; cycles(1);
    expect_bit("R9 sleep req", nmi_req_o, 1'b1);
    sleep_i = 1'b0; cycles(1);
    tag = "R10"; blk_override_i = 1'b1; cycles(1);
    expect_bit("R10 override req", nmi_req_o, 1'b1);
    mask_upd_en_i = 1'b1; accept_now();
    blk_override_i = 1'b0; cpu_block_i = 1'b0;

    tag = "R7"; nmi_pin_i = 1'b1; cycles(4); nmi_pin_i = 1'b0; cycles(4);
    nmi_pin_i = 1'b1; cycles(4);
    nmi_pin_i = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    accept_i = 1'b1; @(negedge clk); accept_i = 1'b0;
    expect_bit("R7 edge beats clear", nmi_pend_o, 1'b1);
    accept_now();

    tag = "R6";
    for (int i = 0; i < 3000; i++) begin
      nmi_pin_i      = ($urandom % 4 == 0) ? ~nmi_pin_i : nmi_pin_i;
      cur_mask_i     = 4'($urandom);
      mask_upd_en_i  = 1'($urandom);
      cpu_block_i    = ($urandom % 3 == 0);
      sleep_i        = ($urandom % 5 == 0);
      blk_override_i = ($urandom % 5 == 0);
      accept_i       = nmi_req_o && ($urandom % 3 == 0);
      if ($urandom % 60 == 0) begin
        edge_rise_i = ~edge_rise_i; edge_sel_wr_i = 1'b1;
      end else edge_sel_wr_i = 1'b0;
      @(negedge clk);
    end
    accept_i = 1'b0; edge_sel_wr_i = 1'b0;
    cycles(2);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule